// File: doc/BRIEF.md
# Masked Palette Color Translator

This block turns a high-color or true-color pixel word into the three final DAC codes for red, green and blue. A programmable 24-bit AND mask is applied to the raw pixel first. The masked word is then split into its three components according to the pixel format tag. Narrow 5-bit and 6-bit fields are left-aligned into 8-bit codes.

When palette translation is enabled, each component separately addresses a 256-entry palette. Red keeps only the red field of the entry it selects, green keeps only the green field, and blue keeps only the blue field. When translation is off, the expanded components go straight to the output. A 6-bit DAC setting scales every code down by two bits. The palette has three read ports, so the block accepts one pixel on every clock. Results appear with a fixed latency of two clocks, and the outputs are zero while the input is blanked.

Top module: `lut_color_xlat`

## Requirements
- R1: The masked pixel equals `pixel_i & mask_i` and is the only source of every output. In 24-bit format (mode 2 or 3) the masked word is split as red = bits 23:16, green = bits 15:8 and blue = bits 7:0.
- R2: In 15-bit format (mode 0), red = bits 14:10, green = bits 9:5 and blue = bits 4:0 of the masked word. Each field lands in code bits 7:3, and the lower code bits are zero.
- R3: In 16-bit format (mode 1), red = bits 15:11 goes to code bits 7:3, green = bits 10:5 goes to code bits 7:2, and blue = bits 4:0 goes to code bits 7:3. The remaining code bits are zero.
- R4: With `ext15_i` set in 15-bit format, masked bit 15 is copied into bit 0 of all three codes. `ext15_i` has no effect in the 16-bit and 24-bit formats.
- R5: With `lut_en_i` set, the red code indexes the palette and its output is entry bits 23:16. The green code takes entry bits 15:8 of its own entry, and the blue code takes entry bits 7:0 of its own entry.
- R6: With `lut_en_i` clear, palette contents do not affect the output.
- R7: With `dac8_i` clear, every output equals its 8-bit result shifted right by two, so bits 7:6 are zero.
- R8: `valid_o` and the codes for a pixel appear exactly two clocks after that pixel is sampled with `valid_i` high.
- R9: While `valid_o` is low, all three codes are zero.
- R10: During reset, `valid_o` and all codes are zero.
- R11: Back-to-back pixels, one per clock, are each translated without a stall.
- R12: A palette write (`pal_we_i`) stores `pal_data_i` at `pal_addr_i` on the clock edge. Lookups issued after that edge see the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Pixel valid; low means blanking |
| pixel_i | input | 24 | Assembled pixel word |
| mode_i | input | 2 | Format: 0 = 15-bit, 1 = 16-bit, 2/3 = 24-bit |
| mask_i | input | 24 | AND mask applied to the pixel |
| lut_en_i | input | 1 | Enable per-component palette translation |
| ext15_i | input | 1 | Extended 15-bit low-bit fill |
| dac8_i | input | 1 | 1 = 8-bit DAC codes, 0 = 6-bit |
| pal_we_i | input | 1 | Palette write enable |
| pal_addr_i | input | 8 | Palette write address |
| pal_data_i | input | 24 | Palette entry {red, green, blue} |
| valid_o | output | 1 | Output codes valid |
| red_o | output | 8 | Red DAC code |
| green_o | output | 8 | Green DAC code |
| blue_o | output | 8 | Blue DAC code |

## Verification
Every pixel result is due two rising edges after the negative edge at which the pixel is driven. The bench keeps a two-deep queue of expected values. On each negative edge it compares the outputs with the entry queued two cycles earlier, and only then drives the next input. Pixels are therefore streamed at full rate, and each check still lands on the cycle its result is due. Palette loads happen while the input is blanked, at least one edge before any lookup that uses them.

// File: rtl/lut_xlat_pkg.sv
package lut_xlat_pkg;
  localparam int COMP_W = 8;
  localparam int NCH    = 3;
  localparam int PIX_W  = NCH * COMP_W;

  typedef logic [COMP_W-1:0] comp_t;
  typedef logic [PIX_W-1:0]  pix_t;

  typedef enum logic [1:0] {
    FMT_555  = 2'd0,
    FMT_565  = 2'd1,
    FMT_888  = 2'd2,
    FMT_888B = 2'd3
  } fmt_e;
endpackage

// File: rtl/lut_xlat_unpack.sv
module lut_xlat_unpack
  import lut_xlat_pkg::*;
(
  input  pix_t                  pixel_i,
  input  pix_t                  mask_i,
  input  logic [1:0]            mode_i,
  input  logic                  ext15_i,
  output logic [NCH-1:0][COMP_W-1:0] comp_o  // [2]=red [1]=green [0]=blue
);
  pix_t m;
  logic fill;

  assign m    = pixel_i & mask_i;
  assign fill = ext15_i & m[15];

  always_comb begin
    unique case (fmt_e'(mode_i))
      FMT_555: begin
        comp_o[2] = {m[14:10], 2'b00, fill};
        comp_o[1] = {m[9:5],   2'b00, fill};
        comp_o[0] = {m[4:0],   2'b00, fill};
      end
      FMT_565: begin
        comp_o[2] = {m[15:11], 3'b000};
        comp_o[1] = {m[10:5],  2'b00};
        comp_o[0] = {m[4:0],   3'b000};
      end
      default: begin
        comp_o[2] = m[23:16];
        comp_o[1] = m[15:8];
        comp_o[0] = m[7:0];
      end
    endcase
  end
endmodule

// File: rtl/lut_xlat_palette.sv
module lut_xlat_palette
  import lut_xlat_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                   clk_i,
  input  logic                   we_i,
  input  logic [AW-1:0]          waddr_i,
  input  pix_t                   wdata_i,
  input  logic [NCH-1:0][AW-1:0] raddr_i,
  output pix_t [NCH-1:0]         rdata_o
);
  pix_t mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  // one independent read port per channel
  for (genvar k = 0; k < NCH; k++) begin : g_rd
    assign rdata_o[k] = mem[raddr_i[k]];
  end
endmodule

// File: rtl/lut_xlat_outstage.sv
module lut_xlat_outstage
  import lut_xlat_pkg::*;
(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       valid_i,
  input  logic                       lut_en_i,
  input  logic                       dac8_i,
  input  logic [NCH-1:0][COMP_W-1:0] comp_i,
  input  pix_t [NCH-1:0]             entry_i,
  output logic                       valid_o,
  output logic [NCH-1:0][COMP_W-1:0] code_o
);
  logic [NCH-1:0][COMP_W-1:0] code_d;

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    comp_t sel;
    // channel k keeps only its own field of its own entry
    assign sel       = lut_en_i ? entry_i[k][k*COMP_W +: COMP_W] : comp_i[k];
    assign code_d[k] = !valid_i ? '0 : (dac8_i ? sel : comp_t'(sel >> 2));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      code_o  <= '0;
    end else begin
      valid_o <= valid_i;
      code_o  <= code_d;
    end
  end
endmodule

// File: rtl/lut_color_xlat.sv
module lut_color_xlat
  import lut_xlat_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [23:0]   pixel_i,
  input  logic [1:0]    mode_i,
  input  logic [23:0]   mask_i,
  input  logic          lut_en_i,
  input  logic          ext15_i,
  input  logic          dac8_i,
  input  logic          pal_we_i,
  input  logic [AW-1:0] pal_addr_i,
  input  logic [23:0]   pal_data_i,
  output logic          valid_o,
  output logic [7:0]    red_o,
  output logic [7:0]    green_o,
  output logic [7:0]    blue_o
);
  logic [NCH-1:0][COMP_W-1:0] comp_d, comp_q, code;
  pix_t [NCH-1:0]             entry;
  logic [NCH-1:0][AW-1:0]     ridx;
  logic                       v_q, lut_q, dac_q;

  lut_xlat_unpack i_unpack (
    .pixel_i (pixel_i),
    .mask_i  (mask_i),
    .mode_i  (mode_i),
    .ext15_i (ext15_i),
    .comp_o  (comp_d)
  );

  // stage 1: expanded components and controls
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q    <= 1'b0;
      lut_q  <= 1'b0;
      dac_q  <= 1'b0;
      comp_q <= '0;
    end else begin
      v_q    <= valid_i;
      lut_q  <= lut_en_i;
      dac_q  <= dac8_i;
      comp_q <= comp_d;
    end
  end

  for (genvar k = 0; k < NCH; k++) begin : g_idx
    assign ridx[k] = AW'(comp_q[k]);
  end

  lut_xlat_palette #(.DEPTH(DEPTH)) i_pal (
    .clk_i   (clk_i),
    .we_i    (pal_we_i),
    .waddr_i (pal_addr_i),
    .wdata_i (pal_data_i),
    .raddr_i (ridx),
    .rdata_o (entry)
  );

  // stage 2: lookup select, DAC width, blanking
  lut_xlat_outstage i_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (v_q),
    .lut_en_i (lut_q),
    .dac8_i   (dac_q),
    .comp_i   (comp_q),
    .entry_i  (entry),
    .valid_o  (valid_o),
    .code_o   (code)
  );

  assign red_o   = code[2];
  assign green_o = code[1];
  assign blue_o  = code[0];
endmodule

// File: rtl/lut_color_xlat_chk.sv
module lut_color_xlat_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [23:0] pixel_i,
  input logic [1:0]  mode_i,
  input logic [23:0] mask_i,
  input logic        lut_en_i,
  input logic        dac8_i,
  input logic        valid_o,
  input logic [7:0]  red_o,
  input logic [7:0]  green_o,
  input logic [7:0]  blue_o
);
  logic [1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  // R8
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2) |-> (valid_o == $past(valid_i, 2)));

  // R9
  blank_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ({red_o, green_o, blue_o} == 24'h0));

  // R7
  dac6_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((age_q == 2'd2) && valid_o && !$past(dac8_i, 2)) |->
      ((red_o[7:6] | green_o[7:6] | blue_o[7:6]) == 2'b00));

  // R6
  pass_true_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((age_q == 2'd2) && valid_o && !$past(lut_en_i, 2) && $past(dac8_i, 2)
      && ($past(mode_i, 2) == 2'd2)) |->
      ({red_o, green_o, blue_o} == $past(pixel_i & mask_i, 2)));

  // R10
  reset_idle_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && ({red_o, green_o, blue_o} == 24'h0)));
endmodule

bind lut_color_xlat lut_color_xlat_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .pixel_i  (pixel_i),
  .mode_i   (mode_i),
  .mask_i   (mask_i),
  .lut_en_i (lut_en_i),
  .dac8_i   (dac8_i),
  .valid_o  (valid_o),
  .red_o    (red_o),
  .green_o  (green_o),
  .blue_o   (blue_o)
);

// File: tb/test_lut_color_xlat.sv
`timescale 1ns/1ps
module test_lut_color_xlat;
  localparam real HALF = 4.0;  // 125 MHz

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [23:0] pixel = '0;
  logic [1:0]  mode = '0;
  logic [23:0] mask = '1;
  logic        lut_en = 1'b0;
  logic        ext15 = 1'b0;
  logic        dac8 = 1'b1;
  logic        pal_we = 1'b0;
  logic [7:0]  pal_addr = '0;
  logic [23:0] pal_data = '0;
  logic        valid_o;
  logic [7:0]  red_o, green_o, blue_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [23:0] pal_m [256];
  logic [24:0] e0 = '0, e1 = '0;
  bit          t0 = 1'b0, t1 = 1'b0;
  string       g0 = "", g1 = "";

  always #(HALF) clk = ~clk;

  lut_color_xlat i_lut_color_xlat (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .pixel_i(pixel),
    .mode_i(mode), .mask_i(mask), .lut_en_i(lut_en), .ext15_i(ext15),
    .dac8_i(dac8), .pal_we_i(pal_we), .pal_addr_i(pal_addr),
    .pal_data_i(pal_data), .valid_o(valid_o), .red_o(red_o),
    .green_o(green_o), .blue_o(blue_o)
  );

  function automatic logic [23:0] pal_fn(int i);
    logic [7:0] a = 8'(i);
    return {a ^ 8'h5A, ~a, 8'(i * 3 + 17)};
  endfunction

  function automatic logic [24:0] model(logic v, logic [23:0] p, logic [1:0] md,
                                        logic [23:0] mk, logic lu, logic ex, logic d8);
    int m = int'(p & mk);
    int c[3];
    int lo;
    if (!v) return '0;
    if (md == 2'd0) begin
      lo = (ex && ((m >> 15) & 1) == 1) ? 1 : 0;
      c[2] = ((m >> 10) & 31) * 8 + lo;
      c[1] = ((m >> 5) & 31) * 8 + lo;
      c[0] = (m & 31) * 8 + lo;
    end else if (md == 2'd1) begin
      c[2] = ((m >> 11) & 31) * 8;
      c[1] = ((m >> 5) & 63) * 4;
      c[0] = (m & 31) * 8;
    end else begin
      c[2] = (m >> 16) & 255;
      c[1] = (m >> 8) & 255;
      c[0] = m & 255;
    end
    for (int k = 0; k < 3; k++) begin
      if (lu) c[k] = int'((pal_m[c[k]] >> (8 * k)) & 24'hFF);
      if (!d8) c[k] = c[k] / 4;
    end
    return {1'b1, 8'(c[2]), 8'(c[1]), 8'(c[0])};
  endfunction

  task automatic cyc(logic v, logic [23:0] p, logic [1:0] md, logic [23:0] mk,
                     logic lu, logic ex, logic d8, string tag);
    @(negedge clk);
    if (t1) begin
      checks++;
      if ({valid_o, red_o, green_o, blue_o} !== e1) begin
        errors++;
        $display("FAIL %s: got %h expected %h", g1,
                 {valid_o, red_o, green_o, blue_o}, e1);
      end
    end
    e1 = e0; t1 = t0; g1 = g0;
    e0 = model(v, p, md, mk, lu, ex, d8); t0 = 1'b1; g0 = tag;
    valid = v; pixel = p; mode = md; mask = mk; lut_en = lu; ext15 = ex; dac8 = d8;
  endtask

  initial begin
    #(HALF * 2 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL R11: watchdog expired, got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    checks++;
    if ({valid_o, red_o, green_o, blue_o} !== 25'h0) begin
      errors++;
      $display("FAIL R10: got %h expected 0", {valid_o, red_o, green_o, blue_o});
    end
    rst_n = 1'b1;

    // R12: load palette while blanked (R9 checked meanwhile)
    for (int i = 0; i < 256; i++) begin
      pal_m[i] = pal_fn(i);
      pal_we = 1'b1; pal_addr = 8'(i); pal_data = pal_fn(i);
      cyc(1'b0, 24'(i * 40503), 2'd2, '1, 1'b1, 1'b0, 1'b1, "R9");
    end
    @(negedge clk); pal_we = 1'b0;

    // R2, R11: 15-bit passthrough, full sweep back to back
    for (int v = 0; v < 32768; v++)
      cyc(1'b1, 24'(v), 2'd0, '1, 1'b0, 1'b0, 1'b1, "R2");
    // R4: ext fill in 15-bit mode
    for (int v = 0; v < 65536; v += 7)
      cyc(1'b1, 24'(v), 2'd0, '1, 1'b0, 1'b1, 1'b1, "R4");
    // R3: 16-bit passthrough
    for (int v = 0; v < 65536; v += 3)
      cyc(1'b1, 24'(v), 2'd1, '1, 1'b0, 1'b0, 1'b1, "R3");
    // R4: ext flag ignored in 16/24-bit formats
    for (int v = 0; v < 2048; v++)
      cyc(1'b1, 24'(v * 97 + 32768), 2'(1 + v % 3), '1, 1'b0, 1'b1, 1'b1, "R4");
    // R1: mask in 24-bit format and on narrow formats
    for (int v = 0; v < 4096; v++)
      cyc(1'b1, 24'(v * 4099 + 12345), 2'(v % 4), 24'(v * 7919 ^ 24'hF0F0F0),
          1'b0, v[0], 1'b1, "R1");
    // R5: per-component lookup, all index values
    for (int i = 0; i < 256; i++)
      cyc(1'b1, {8'(i), 8'(i + 85), 8'(255 - i)}, 2'd2, '1, 1'b1, 1'b0, 1'b1, "R5");
    for (int v = 0; v < 4096; v++)
      cyc(1'b1, 24'(v * 16 + v), 2'(v % 3), 24'(~(v * 3)), 1'b1, v[1], 1'b1, "R5");
    // R6: translation off ignores palette
    for (int i = 0; i < 256; i++)
      cyc(1'b1, 24'(i * 65793), 2'd2, '1, 1'b0, 1'b0, 1'b1, "R6");
    // R7: 6-bit DAC, with and without lookup
    for (int v = 0; v < 1024; v++)
      cyc(1'b1, 24'(v * 16411), 2'(v % 3), '1, v[0], 1'b0, 1'b0, "R7");
    // R9: blanking interleaved with valid pixels
    for (int v = 0; v < 512; v++)
      cyc(v[0], 24'hFFFFFF - 24'(v), 2'd2, '1, v[1], 1'b0, 1'b1, "R9");
    // R8: isolated pixels between idle cycles
    for (int v = 0; v < 64; v++) begin
      cyc(1'b1, 24'(v * 262657), 2'd2, '1, 1'b0, 1'b0, 1'b1, "R8");
      cyc(1'b0, 24'h0, 2'd2, '1, 1'b0, 1'b0, 1'b1, "R8");
      cyc(1'b0, 24'h0, 2'd2, '1, 1'b0, 1'b0, 1'b1, "R8");
    end
    // R12: rewrite one entry, then look it up
    @(negedge clk);
    pal_we = 1'b1; pal_addr = 8'h3C; pal_data = 24'h123456; pal_m[8'h3C] = 24'h123456;
    cyc(1'b0, 24'h0, 2'd2, '1, 1'b1, 1'b0, 1'b1, "R12");
    pal_we = 1'b0;
    cyc(1'b1, 24'h3C3C3C, 2'd2, '1, 1'b1, 1'b0, 1'b1, "R12");
    // flush
    cyc(1'b0, 24'h0, 2'd2, '1, 1'b0, 1'b0, 1'b1, "R9");
    cyc(1'b0, 24'h0, 2'd2, '1, 1'b0, 1'b0, 1'b1, "R9");
    cyc(1'b0, 24'h0, 2'd2, '1, 1'b0, 1'b0, 1'b1, "R9");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule